// File: doc/BRIEF.md
# Dual-Lane Serial Result Formatter

This block turns a set of parallel result words into two bit-serial streams. A result producer presents up to eight 16-bit results at once: in-phase, quadrature, magnitude, phase, frequency, gain level, timing error and one spare. A one-cycle load strobe marks each new set. Each of the two serial lanes has its own list of up to four slots. Each slot names which result goes out in that position. The lane shifts the chosen words out one after another, most significant bit first. It advances by one bit time on every cycle where the serial clock enable is high.

Each lane also drives a framing strobe that takes up exactly one bit time. In early mode the strobe comes just before the first data bit. In late mode it comes just after the final data bit. The strobe can be active high or active low. Each word can be cut to fewer than 16 bits, in which case only its upper bits are sent. A new load always abandons the frame in progress and restarts both lanes. One ordering rule, applied the same way to both lanes, can force magnitude into the slot that follows quadrature.

Top module: `ser_out_fmt`

## Requirements
- R1: On a load, each lane captures the words it selected at that moment. It then sends its words in slot order, slot 0 first, each most significant bit first, one bit per enabled cycle. Later changes on the result inputs do not alter a frame already loaded.
- R2: The per-lane word count input holds the number of words minus one: 0 means one word and 3 means four words. The two lanes may use different counts.
- R3: The length input holds the number of bits per word minus one, from 0 to 15. Each word sends only its upper (length+1) bits, starting at bit 15.
- R4: In early mode (late select = 0), the strobe is active for the single bit time after a load. The data line is 0 during that bit time, and bit 15 of the first word follows it.
- R5: In late mode (late select = 1), data starts in the first bit time after a load. The strobe is active for the single bit time after the last bit of the last word.
- R6: With the invert input at 0 the strobe is active high. With it at 1 the strobe is active low, so its inactive level is 1. The invert input acts at once and is not captured at load.
- R7: A load restarts both lanes at the next bit time, whatever state they are in, and it takes effect even when the serial enable is low. Word count, length, sync mode and slot selection are sampled at the load.
- R8: In late mode, if a new load always arrives before the last bit of the last word, the strobe never becomes active.
- R9: While the serial enable is low and no load is present, both lanes hold their data and strobe outputs unchanged.
- R10: Result codes are I=0, Q=1, magnitude=2, phase=3, frequency=4, gain level=5, timing error=6 and spare=7. Slot k occupies bits [3k+2:3k] of a lane's selection input. When the ordering rule input is 1, any slot whose configured predecessor selects Q sends magnitude instead, on both lanes.
- R11: After reset, and after a frame completes with no new load, each data line is 0 and each strobe sits at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_en | input | 1 | Serial bit-time enable |
| load | input | 1 | New result set strobe |
| src_words | input | 128 | Eight 16-bit results; result n occupies bits [16n+15:16n] |
| cfg_cnt_a | input | 2 | Lane A word count minus one |
| cfg_cnt_b | input | 2 | Lane B word count minus one |
| cfg_sel_a | input | 12 | Lane A slot list, 3 bits per slot |
| cfg_sel_b | input | 12 | Lane B slot list, 3 bits per slot |
| cfg_len | input | 4 | Bits per word minus one |
| cfg_late | input | 1 | 1: strobe after the last bit; 0: strobe before the first bit |
| cfg_inv | input | 1 | 1: strobe active low |
| cfg_mag_after_q | input | 1 | Ordering rule enable |
| ser_a | output | 1 | Lane A serial data |
| ser_b | output | 1 | Lane B serial data |
| sync_a | output | 1 | Lane A framing strobe |
| sync_b | output | 1 | Lane B framing strobe |

## Verification
Several properties are checked on every cycle:
- The lane holds its state while the enable is low.
- Each load restarts the lane at bit 15 of slot 0 in the chosen sync mode.
- The bit and word counters stay inside their programmed limits.
- The trailing strobe appears only in late mode.
- A lane outputs nothing while idle.
- The two lanes stay aligned at the start of a frame.
- The magnitude ordering rule holds on both lanes.

Other behaviours can only be shown by bench scenarios. These include the exact bit content and order of each frame for different counts, lengths, polarities and slot lists. They also include frames resuming correctly after an enable gap, and frames unaffected by result changes after capture. Two cases depend on long sequences of stimulus: a late strobe that never appears under repeated preemption, and a restart from the middle of a frame.

// File: rtl/sof_pkg.sv
// Shared definitions for the serial result formatter.
// Assumes 3-bit result codes; lane state encoding is local to this package.
package sof_pkg;

    // Lane sequencing phases: idle, leading strobe, data, trailing strobe
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PRE  = 2'd1,
        PH_DATA = 2'd2,
        PH_POST = 2'd3
    } lane_phase_e;

    // Result codes on the parallel source bus
    localparam int SRC_I     = 0;
    localparam int SRC_Q     = 1;
    localparam int SRC_MAG   = 2;
    localparam int SRC_PHASE = 3;
    localparam int SRC_FREQ  = 4;
    localparam int SRC_AGC   = 5;
    localparam int SRC_TERR  = 6;

endpackage

// File: rtl/sof_slot_map.sv
// Slot map: picks one source word per slot for a lane and applies the
// shared ordering rule (slot after a configured Q slot becomes magnitude).
// Assumes NUM_SRC is a power of two so every select code addresses a word.
module sof_slot_map
    import sof_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int MAX_WORDS = 4,
    parameter int NUM_SRC   = 8
) (
    input  logic [NUM_SRC*WORD_W-1:0]            src_flat,
    input  logic [MAX_WORDS*$clog2(NUM_SRC)-1:0] sel_flat,
    input  logic                                 mag_rule,
    output logic [MAX_WORDS*WORD_W-1:0]          words_flat
);

    localparam int SEL_W = $clog2(NUM_SRC);
    localparam logic [SEL_W-1:0] CODE_Q   = SEL_W'(SRC_Q);
    localparam logic [SEL_W-1:0] CODE_MAG = SEL_W'(SRC_MAG);

    logic [SEL_W-1:0] eff_sel [MAX_WORDS];

    // Resolve the effective code of every slot from the configured list
    always_comb begin
        for (int k = 0; k < MAX_WORDS; k++) begin
            eff_sel[k] = sel_flat[k*SEL_W +: SEL_W];
            if (mag_rule && (k > 0) && (sel_flat[(k-1)*SEL_W +: SEL_W] == CODE_Q)) begin
                eff_sel[k] = CODE_MAG;
            end
        end
    end

    // One word multiplexer per slot
    for (genvar gk = 0; gk < MAX_WORDS; gk++) begin : g_slot
        assign words_flat[gk*WORD_W +: WORD_W] = src_flat[int'(eff_sel[gk])*WORD_W +: WORD_W];
    end

    // Rule check: a slot that follows a configured Q slot carries the magnitude word
    always_comb begin
        for (int k = 1; k < MAX_WORDS; k++) begin
            if (mag_rule && (sel_flat[(k-1)*SEL_W +: SEL_W] == CODE_Q)) begin
                assert_mag_follows_q_R10: assert (words_flat[k*WORD_W +: WORD_W] ==
                                                  src_flat[SRC_MAG*WORD_W +: WORD_W])
                    else $error("slot %0d does not carry magnitude", k);
            end
        end
    end

endmodule

// File: rtl/sof_lane.sv
// Serial lane: captures a frame of words on load and shifts them out MSB
// first, one bit per enabled cycle, with a one-bit-time framing strobe
// before the first bit (early) or after the last bit (late).
// Assumes WORD_W is a power of two; words are truncated to their top bits.
module sof_lane
    import sof_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int MAX_WORDS = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   ser_en,
    input  logic                                   load,
    input  logic [MAX_WORDS*WORD_W-1:0]            words_in,
    input  logic [((MAX_WORDS>1)?$clog2(MAX_WORDS):1)-1:0] cnt_in,
    input  logic [$clog2(WORD_W)-1:0]              len_in,
    input  logic                                   late_in,
    input  logic                                   inv_in,
    output logic                                   ser_o,
    output logic                                   sync_o
);

    localparam int LEN_W = $clog2(WORD_W);
    localparam int CNT_W = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;
    localparam logic [LEN_W-1:0] TOP_BIT = LEN_W'(WORD_W - 1);

    lane_phase_e                 phase_q, phase_d;
    logic [MAX_WORDS*WORD_W-1:0] buf_q, buf_d;
    logic [CNT_W-1:0]            word_q, word_d;
    logic [CNT_W-1:0]            cnt_q, cnt_d;
    logic [LEN_W-1:0]            bit_q, bit_d;
    logic [LEN_W-1:0]            stop_q, stop_d;
    logic                        late_q, late_d;
    logic [WORD_W-1:0]           cur_word;

    // Next-state: load restarts the frame, otherwise advance per enabled bit time
    always_comb begin
        phase_d = phase_q;
        buf_d   = buf_q;
        word_d  = word_q;
        cnt_d   = cnt_q;
        bit_d   = bit_q;
        stop_d  = stop_q;
        late_d  = late_q;
        if (load) begin
            phase_d = late_in ? PH_DATA : PH_PRE;
            buf_d   = words_in;
            word_d  = '0;
            cnt_d   = cnt_in;
            bit_d   = TOP_BIT;
            stop_d  = TOP_BIT - len_in;
            late_d  = late_in;
        end else if (ser_en) begin
            case (phase_q)
                PH_PRE: phase_d = PH_DATA;
                PH_DATA: begin
                    if (bit_q == stop_q) begin
                        bit_d = TOP_BIT;
                        if (word_q == cnt_q) begin
                            phase_d = late_q ? PH_POST : PH_IDLE;
                        end else begin
                            word_d = word_q + 1'b1;
                        end
                    end else begin
                        bit_d = bit_q - 1'b1;
                    end
                end
                PH_POST: phase_d = PH_IDLE;
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    // State registers with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            buf_q   <= '0;
            word_q  <= '0;
            cnt_q   <= '0;
            bit_q   <= '0;
            stop_q  <= '0;
            late_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            buf_q   <= buf_d;
            word_q  <= word_d;
            cnt_q   <= cnt_d;
            bit_q   <= bit_d;
            stop_q  <= stop_d;
            late_q  <= late_d;
        end
    end

    // Output decode: current bit in data phase, strobe in either strobe phase
    assign cur_word = buf_q[int'(word_q)*WORD_W +: WORD_W];
    assign ser_o    = (phase_q == PH_DATA) && cur_word[bit_q];
    assign sync_o   = ((phase_q == PH_PRE) || (phase_q == PH_POST)) ^ inv_in;

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_en && !load) |=> ($stable(phase_q) && $stable(bit_q) && $stable(word_q)))
        else $error("lane advanced without enable");

    assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ((word_q == '0) && (bit_q == TOP_BIT) &&
                  (phase_q == ($past(late_in) ? PH_DATA : PH_PRE))))
        else $error("load did not restart the frame");

    assert_bit_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DATA) |-> (bit_q >= stop_q))
        else $error("bit index past programmed length");

    assert_word_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        word_q <= cnt_q)
        else $error("word index past programmed count");

    assert_post_late_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_POST) |-> late_q)
        else $error("trailing strobe in early mode");

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE) |-> (!ser_o && (sync_o == inv_in)))
        else $error("idle lane not quiet");

endmodule

// File: rtl/ser_out_fmt.sv
// Two-lane serial result formatter: each lane selects its own list of
// result words, both lanes restart together on load and share length,
// sync mode, polarity and the ordering rule.
// Assumes the result bus is stable in the cycle load is high.
module ser_out_fmt
    import sof_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int MAX_WORDS = 4,
    parameter int NUM_SRC   = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 ser_en,
    input  logic                                 load,
    input  logic [NUM_SRC*WORD_W-1:0]            src_words,
    input  logic [((MAX_WORDS>1)?$clog2(MAX_WORDS):1)-1:0] cfg_cnt_a,
    input  logic [((MAX_WORDS>1)?$clog2(MAX_WORDS):1)-1:0] cfg_cnt_b,
    input  logic [MAX_WORDS*$clog2(NUM_SRC)-1:0] cfg_sel_a,
    input  logic [MAX_WORDS*$clog2(NUM_SRC)-1:0] cfg_sel_b,
    input  logic [$clog2(WORD_W)-1:0]            cfg_len,
    input  logic                                 cfg_late,
    input  logic                                 cfg_inv,
    input  logic                                 cfg_mag_after_q,
    output logic                                 ser_a,
    output logic                                 ser_b,
    output logic                                 sync_a,
    output logic                                 sync_b
);

    localparam int N_LANES = 2;
    localparam int SEL_W   = $clog2(NUM_SRC);
    localparam int CNT_W   = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;

    logic [N_LANES-1:0][MAX_WORDS*SEL_W-1:0]  sel_l;
    logic [N_LANES-1:0][CNT_W-1:0]            cnt_l;
    logic [N_LANES-1:0][MAX_WORDS*WORD_W-1:0] words_l;
    logic [N_LANES-1:0]                       ser_l;
    logic [N_LANES-1:0]                       sync_l;

    assign sel_l[0] = cfg_sel_a;
    assign sel_l[1] = cfg_sel_b;
    assign cnt_l[0] = cfg_cnt_a;
    assign cnt_l[1] = cfg_cnt_b;

    // One slot map and one shifting lane per serial output
    for (genvar gl = 0; gl < N_LANES; gl++) begin : g_lane
        sof_slot_map #(
            .WORD_W    (WORD_W),
            .MAX_WORDS (MAX_WORDS),
            .NUM_SRC   (NUM_SRC)
        ) i_map (
            .src_flat   (src_words),
            .sel_flat   (sel_l[gl]),
            .mag_rule   (cfg_mag_after_q),
            .words_flat (words_l[gl])
        );

        sof_lane #(
            .WORD_W    (WORD_W),
            .MAX_WORDS (MAX_WORDS)
        ) i_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .ser_en   (ser_en),
            .load     (load),
            .words_in (words_l[gl]),
            .cnt_in   (cnt_l[gl]),
            .len_in   (cfg_len),
            .late_in  (cfg_late),
            .inv_in   (cfg_inv),
            .ser_o    (ser_l[gl]),
            .sync_o   (sync_l[gl])
        );
    end

    assign ser_a  = ser_l[0];
    assign ser_b  = ser_l[1];
    assign sync_a = sync_l[0];
    assign sync_b = sync_l[1];

    // Both lanes raise the leading strobe in the same bit time after an early-mode load
    assert_lanes_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !cfg_late) |=> ((sync_a == sync_b) && (sync_a != cfg_inv) && !ser_a && !ser_b))
        else $error("lanes not aligned on leading strobe");

endmodule

// File: tb/test_ser_out_fmt.sv
`timescale 1ns/1ps
module test_ser_out_fmt;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         ser_en;
    logic         load;
    logic [127:0] src_words;
    logic [1:0]   cfg_cnt_a, cfg_cnt_b;
    logic [11:0]  cfg_sel_a, cfg_sel_b;
    logic [3:0]   cfg_len;
    logic         cfg_late, cfg_inv, cfg_mag_after_q;
    logic         ser_a, ser_b, sync_a, sync_b;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ser_out_fmt i_ser_out_fmt (
        .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .load(load), .src_words(src_words),
        .cfg_cnt_a(cfg_cnt_a), .cfg_cnt_b(cfg_cnt_b), .cfg_sel_a(cfg_sel_a), .cfg_sel_b(cfg_sel_b),
        .cfg_len(cfg_len), .cfg_late(cfg_late), .cfg_inv(cfg_inv), .cfg_mag_after_q(cfg_mag_after_q),
        .ser_a(ser_a), .ser_b(ser_b), .sync_a(sync_a), .sync_b(sync_b)
    );

    // Vector layout: [34] rule, [33] inv, [32] late, [31:28] len, [27:26] cnt_b,
    // [25:24] cnt_a, [23:12] sel_b, [11:0] sel_a (slot 0 in the low bits)
    localparam int NVEC = 6;
    localparam logic [34:0] VECS [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 4'd15, 2'd2, 2'd2, {3'd0, 3'd3, 3'd2, 3'd1}, {3'd0, 3'd2, 3'd1, 3'd0}},
        {1'b0, 1'b0, 1'b1, 4'd15, 2'd3, 2'd0, {3'd7, 3'd6, 3'd5, 3'd4}, {3'd0, 3'd0, 3'd0, 3'd0}},
        {1'b0, 1'b1, 1'b0, 4'd7,  2'd1, 2'd1, {3'd0, 3'd0, 3'd6, 3'd3}, {3'd0, 3'd0, 3'd5, 3'd2}},
        {1'b0, 1'b1, 1'b1, 4'd3,  2'd2, 2'd3, {3'd0, 3'd1, 3'd4, 3'd7}, {3'd3, 3'd2, 3'd1, 3'd0}},
        {1'b1, 1'b0, 1'b0, 4'd15, 2'd3, 2'd3, {3'd6, 3'd1, 3'd5, 3'd1}, {3'd4, 3'd3, 3'd1, 3'd0}},
        {1'b0, 1'b0, 1'b1, 4'd0,  2'd3, 2'd3, {3'd1, 3'd3, 3'd5, 3'd7}, {3'd6, 3'd4, 3'd2, 3'd0}}
    };
    localparam int NSAMP = 70;

    function automatic logic [15:0] src_val(input int i);
        return 16'((i + 1) * 16'h2F57) ^ 16'hC3A5;
    endfunction

    // Effective result code of a slot, with the magnitude-after-Q rule (R10)
    function automatic int eff_sel(input logic [34:0] v, input int lane, input int w);
        logic [11:0] s;
        s = lane ? v[23:12] : v[11:0];
        if (v[34] && w > 0 && s[(w-1)*3 +: 3] == 3'd1) return 2;
        return int'(s[w*3 +: 3]);
    endfunction

    function automatic logic exp_data(input logic [34:0] v, input int lane, input int t);
        int pre, n, blen, idx;
        logic [15:0] wv;
        pre  = v[32] ? 0 : 1;
        n    = (lane ? int'(v[27:26]) : int'(v[25:24])) + 1;
        blen = int'(v[31:28]) + 1;
        idx  = t - pre;
        if (idx < 0 || idx >= n * blen) return 1'b0;
        wv = src_val(eff_sel(v, lane, idx / blen));
        return wv[15 - (idx % blen)];
    endfunction

    function automatic logic exp_sync(input logic [34:0] v, input int lane, input int t);
        int n, blen;
        logic act;
        n    = (lane ? int'(v[27:26]) : int'(v[25:24])) + 1;
        blen = int'(v[31:28]) + 1;
        act  = v[32] ? (t == n * blen) : (t == 0);
        return act ^ v[33];
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic apply_cfg(input logic [34:0] v);
        cfg_mag_after_q = v[34];
        cfg_inv   = v[33];
        cfg_late  = v[32];
        cfg_len   = v[31:28];
        cfg_cnt_b = v[27:26];
        cfg_cnt_a = v[25:24];
        cfg_sel_b = v[23:12];
        cfg_sel_a = v[11:0];
    endtask

    task automatic restore_src();
        for (int i = 0; i < 8; i++) src_words[i*16 +: 16] = src_val(i);
    endtask

    // Returns at the negedge where bit time 0 of the new frame is visible
    task automatic start_frame(input logic [34:0] v);
        @(negedge clk);
        apply_cfg(v);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    // Compare both lanes against the model over NSAMP bit times
    task automatic check_frame(input logic [34:0] v, input string req, input int hold_at, input bit scramble);
        int mis [4];
        int first_act [4];
        int first_exp [4];
        logic got [4];
        logic want [4];
        for (int j = 0; j < 4; j++) mis[j] = 0;
        for (int t = 0; t < NSAMP; t++) begin
            int reps;
            reps = (t == hold_at) ? 9 : 1;
            if (t == hold_at) ser_en = 1'b0;
            for (int r = 0; r < reps; r++) begin
                got[0] = ser_a;  want[0] = exp_data(v, 0, t);
                got[1] = ser_b;  want[1] = exp_data(v, 1, t);
                got[2] = sync_a; want[2] = exp_sync(v, 0, t);
                got[3] = sync_b; want[3] = exp_sync(v, 1, t);
                for (int j = 0; j < 4; j++) begin
                    if (got[j] !== want[j]) begin
                        if (mis[j] == 0) begin
                            first_act[j] = int'(got[j]);
                            first_exp[j] = int'(want[j]);
                        end
                        mis[j]++;
                    end
                end
                if (r == reps - 1) ser_en = 1'b1;
                if (scramble && t == 3) src_words = ~src_words;
                @(negedge clk);
            end
        end
        restore_src();
        for (int j = 0; j < 4; j++) begin
            string nm;
            nm = (j == 0) ? "ser_a" : (j == 1) ? "ser_b" : (j == 2) ? "sync_a" : "sync_b";
            if (mis[j] != 0)
                $display("  %s %s first mismatch actual=%0d expected=%0d", req, nm, first_act[j], first_exp[j]);
            check(mis[j] == 0, req, {nm, " mismatching bit times"}, mis[j], 0);
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seen;
        rst_n  = 1'b0;
        ser_en = 1'b1;
        load   = 1'b0;
        restore_src();
        apply_cfg(VECS[0]);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state is idle
        check(!ser_a && !ser_b && !sync_a && !sync_b, "R11", "reset outputs {ser_a,ser_b,sync_a,sync_b}",
              int'({ser_a, ser_b, sync_a, sync_b}), 0);

        // Table walk: R1 R2 R3 R4 R5 R6 R10 across counts, lengths, modes and polarity
        for (int k = 0; k < NVEC; k++) begin
            string tag;
            tag = (k == 0) ? "R1/R4" : (k == 1) ? "R2/R5" : (k == 2) ? "R3/R6" :
                  (k == 3) ? "R5/R6" : (k == 4) ? "R10" : "R3";
            start_frame(VECS[k]);
            check_frame(VECS[k], tag, -1, 1'b0);
        end

        // R7: preempt a frame mid-flight, load taken while enable is low
        start_frame(VECS[0]);
        repeat (10) @(negedge clk);
        ser_en = 1'b0;
        start_frame(VECS[4]);
        ser_en = 1'b1;
        check_frame(VECS[4], "R7", -1, 1'b0);

        // R9: enable gap mid-frame holds outputs, then resumes
        start_frame(VECS[3]);
        check_frame(VECS[3], "R9", 5, 1'b0);

        // R1: result bus changes after capture do not alter the frame
        start_frame(VECS[0]);
        check_frame(VECS[0], "R1", -1, 1'b1);

        // R8: late mode, repeated preemption before the end, no strobe
        seen = 0;
        for (int rep = 0; rep < 5; rep++) begin
            start_frame(VECS[1] | 35'h0_0300_0000);
            for (int c = 0; c < 40; c++) begin
                if (sync_a || sync_b) seen++;
                @(negedge clk);
            end
        end
        check(seen == 0, "R8", "strobe active bit times", seen, 0);

        // R11 and R6: idle after completion, then live polarity change on idle strobe
        repeat (80) @(negedge clk);
        check(!ser_a && !ser_b && !sync_a && !sync_b, "R11", "idle outputs after frame",
              int'({ser_a, ser_b, sync_a, sync_b}), 0);
        cfg_inv = 1'b1;
        #1;
        check(sync_a && sync_b && !ser_a && !ser_b, "R6", "idle outputs with invert {ser_a,ser_b,sync_a,sync_b}",
              int'({ser_a, ser_b, sync_a, sync_b}), 3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule